// File: doc/BRIEF.md
# Full-Cycle SPI Master Shift Engine

This block is the host side of a serial flash link that runs a full-clock-cycle variant of SPI. It divides the system clock down to a serial clock, frames every exchange with an active-low chip select, shifts bytes out MSB first and gathers the slave's answer bytes. Each direction gets one whole serial clock period between the edge that launches a bit and the edge that takes it. The master changes its output only when the serial clock rises and samples the slave only when it falls. A slave bit that was launched on one falling edge is taken on the falling edge that follows.

Because the slave launches on falling edges, the first falling-edge sample of a frame carries no data, and each received byte is one serial clock behind its transmitted byte. The engine therefore counts received bits from the second falling edge of the frame. When the frame closes, it adds one trailing serial clock so that the last answer bit can be taken. The user side is a valid/ready byte handshake with a hold flag. A byte sent with hold set keeps chip select low and parks the serial clock low until the next byte is offered. Each answer byte comes back with a one-cycle valid pulse.

Top module: `fcspi_master`

## Requirements
- R1: Out of reset, and at all times while chip select (`cs_n`) is high, `sck` is low. Out of reset `tx_ready` is high and `rx_valid` is low.
- R2: A byte is accepted on a clock where `tx_valid` and `tx_ready` are both high. When a frame opens, `cs_n` goes low at least one system clock before the first rising edge of `sck`.
- R3: While a frame runs, `sck` is high for exactly CLK_DIV/2 system clocks after each rising edge. It is low for at least CLK_DIV/2 system clocks before each rising edge. CLK_DIV is even and at least 2.
- R4: `mosi` changes only on the system clock where `sck` rises. Bits go out MSB first, one per rising edge. Each bit stays stable until the next rising edge, where the slave takes it.
- R5: `miso` is sampled only as `sck` falls. The sample at the first falling edge of a frame is dropped. Received byte j (counting from 0) is built MSB first from the samples at falling edges 8j+2 through 8j+9.
- R6: Each received byte appears on `rx_data` together with a single-cycle `rx_valid` pulse. A frame of N transmitted bytes yields exactly N received bytes.
- R7: After the eighth serial clock of a byte sent with `tx_hold` = 1, `tx_ready` rises while `cs_n` stays low and `sck` stays low. The next accepted byte continues the same frame without an extra serial clock.
- R8: After the last byte of a frame (sent with `tx_hold` = 0), one trailing serial clock is issued with no change on `mosi`. Then `cs_n` goes high. A frame of N bytes has exactly 8N+1 rising `sck` edges.
- R9: `tx_valid` asserted while `tx_ready` is low has no effect: no byte is taken and the frame carries only the accepted bytes.
- R10: `tx_ready` is low from the clock after a byte is accepted until that byte's eighth serial clock has ended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tx_valid | input | 1 | Byte offered for transmission |
| tx_ready | output | 1 | Engine can take a byte |
| tx_data | input | W | Byte to transmit, MSB sent first |
| tx_hold | input | 1 | Keep chip select low after this byte |
| rx_valid | output | 1 | One-cycle pulse marking a received byte |
| rx_data | output | W | Received byte |
| sck | output | 1 | Serial clock, idle low |
| cs_n | output | 1 | Active-low chip select |
| mosi | output | 1 | Serial data to the slave |
| miso | input | 1 | Serial data from the slave |

## Verification
The bench models a full-cycle slave. The slave takes each MOSI bit one rising edge late and answers with bytes derived from what it received earlier. An engine that sampled on the rising edge, or counted from the first falling edge, would return answer bytes shifted by one bit. An engine that changed MOSI outside a rising edge would corrupt the bytes the slave collects. Bursts with long pauses, back-to-back bursts and single-byte frames cover the cases where a missing or doubled trailing clock would change the count of rising edges in a frame. A valid strobe injected in the middle of a byte would show up as an extra byte if the handshake were not gated.

// File: rtl/fcspi_pkg.sv
package fcspi_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_RUN   = 2'd1,
    ST_PAUSE = 2'd2,
    ST_TRAIL = 2'd3
  } fc_state_e;

  // system clocks in each half of a serial clock period
  function automatic int half_period(input int div);
    return div / 2;
  endfunction

  // width of the phase counter that walks one serial clock period
  function automatic int phase_width(input int div);
    return (div > 2) ? $clog2(div) : 1;
  endfunction

  // width of a counter that indexes the bits of one byte
  function automatic int bit_index_width(input int w);
    return (w > 2) ? $clog2(w) : 1;
  endfunction

  // rising edges in a closed frame of n bytes of w bits
  function automatic int frame_rises(input int n, input int w);
    return n * w + 1;
  endfunction

endpackage

// File: rtl/fcspi_sck_gen.sv
module fcspi_sck_gen #(
  parameter int CLK_DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic sck,
  output logic rise_stb,
  output logic fall_stb,
  output logic end_stb
);
  import fcspi_pkg::*;

  localparam int HALF  = half_period(CLK_DIV);
  localparam int CNT_W = phase_width(CLK_DIV);

  logic [CNT_W-1:0] phase;

  assign rise_stb = run && (phase == '0);
  assign fall_stb = run && (phase == CNT_W'(HALF));
  assign end_stb  = run && (phase == CNT_W'(CLK_DIV - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= '0;
    end else if (!run) begin
      phase <= '0;
    end else if (end_stb) begin
      phase <= '0;
    end else begin
      phase <= phase + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck <= 1'b0;
    end else if (rise_stb) begin
      sck <= 1'b1;
    end else if (fall_stb || !run) begin
      sck <= 1'b0;
    end
  end

  initial begin
    assert_div_even_R3 : assert ((CLK_DIV >= 2) && (CLK_DIV % 2 == 0))
      else $error("CLK_DIV must be even and at least 2");
  end

  generate
    if (HALF == 1) begin : g_fast
      assert_high_phase_R3 : assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sck) |=> $fell(sck));
    end else begin : g_slow
      assert_high_phase_R3 : assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sck) |=> sck);
    end
  endgenerate

endmodule

// File: rtl/fcspi_tx_shift.sv
module fcspi_tx_shift #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_data,
  input  logic         shift_stb,
  output logic         mosi
);

  logic [W-1:0] txsh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      txsh <= '0;
      mosi <= 1'b0;
    end else if (load) begin
      txsh <= load_data;
    end else if (shift_stb) begin
      mosi <= txsh[W-1];
      txsh <= {txsh[W-2:0], 1'b0};
    end
  end

endmodule

// File: rtl/fcspi_rx_align.sv
module fcspi_rx_align #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         frame_start,
  input  logic         cap_stb,
  input  logic         miso,
  output logic         rx_valid_o,
  output logic [W-1:0] rx_data_o
);
  import fcspi_pkg::*;

  localparam int BW = bit_index_width(W);

  logic          skip_first;
  logic [W-2:0]  rxsh;
  logic [BW-1:0] bitc;
  logic          take_bit;
  logic          byte_full;

  assign take_bit  = cap_stb && !skip_first;
  assign byte_full = take_bit && (bitc == BW'(W - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      skip_first <= 1'b0;
      rxsh       <= '0;
      bitc       <= '0;
      rx_valid_o <= 1'b0;
      rx_data_o  <= '0;
    end else begin
      rx_valid_o <= 1'b0;
      if (frame_start) begin
        skip_first <= 1'b1;
        bitc       <= '0;
      end else if (cap_stb) begin
        if (skip_first) begin
          skip_first <= 1'b0;
        end else begin
          rxsh <= {rxsh[W-3:0], miso};
          if (byte_full) begin
            rx_valid_o <= 1'b1;
            rx_data_o  <= {rxsh, miso};
            bitc       <= '0;
          end else begin
            bitc <= bitc + 1'b1;
          end
        end
      end
    end
  end

  assert_rx_single_R6 : assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid_o |=> !rx_valid_o);

  assert_rx_on_fall_R5 : assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid_o |-> $past(cap_stb));

endmodule

// File: rtl/fcspi_master.sv
module fcspi_master #(
  parameter int CLK_DIV = 4,
  parameter int W       = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tx_valid,
  output logic         tx_ready,
  input  logic [W-1:0] tx_data,
  input  logic         tx_hold,
  output logic         rx_valid,
  output logic [W-1:0] rx_data,
  output logic         sck,
  output logic         cs_n,
  output logic         mosi,
  input  logic         miso
);
  import fcspi_pkg::*;

  localparam int BW = bit_index_width(W);

  fc_state_e     state;
  logic [BW-1:0] cyc;
  logic          hold_q;

  logic accept;
  logic frame_start;
  logic run;
  logic rise_stb;
  logic fall_stb;
  logic end_stb;
  logic launch_stb;
  logic byte_end;

  assign tx_ready    = (state == ST_IDLE) || (state == ST_PAUSE);
  assign accept      = tx_valid && tx_ready;
  assign frame_start = accept && (state == ST_IDLE);
  assign run         = (state == ST_RUN) || (state == ST_TRAIL);
  assign launch_stb  = rise_stb && (state == ST_RUN);
  assign byte_end    = end_stb && (state == ST_RUN) && (cyc == BW'(W - 1));

  fcspi_sck_gen #(.CLK_DIV(CLK_DIV)) u_sck (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (run),
    .sck      (sck),
    .rise_stb (rise_stb),
    .fall_stb (fall_stb),
    .end_stb  (end_stb)
  );

  fcspi_tx_shift #(.W(W)) u_tx (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (accept),
    .load_data (tx_data),
    .shift_stb (launch_stb),
    .mosi      (mosi)
  );

  fcspi_rx_align #(.W(W)) u_rx (
    .clk         (clk),
    .rst_n       (rst_n),
    .frame_start (frame_start),
    .cap_stb     (fall_stb),
    .miso        (miso),
    .rx_valid_o  (rx_valid),
    .rx_data_o   (rx_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      cyc    <= '0;
      hold_q <= 1'b0;
      cs_n   <= 1'b1;
    end else begin
      case (state)
        ST_IDLE: begin
          if (accept) begin
            state  <= ST_RUN;
            cs_n   <= 1'b0;
            hold_q <= tx_hold;
            cyc    <= '0;
          end
        end
        ST_PAUSE: begin
          if (accept) begin
            state  <= ST_RUN;
            hold_q <= tx_hold;
            cyc    <= '0;
          end
        end
        ST_RUN: begin
          if (byte_end) begin
            state <= hold_q ? ST_PAUSE : ST_TRAIL;
            cyc   <= '0;
          end else if (end_stb) begin
            cyc <= cyc + 1'b1;
          end
        end
        ST_TRAIL: begin
          if (end_stb) begin
            state <= ST_IDLE;
            cs_n  <= 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assert_sck_idle_R1 : assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !sck);

  assert_cs_setup_R2 : assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sck) |-> !$past(cs_n));

  assert_mosi_on_rise_R4 : assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mosi) |-> $rose(sck));

  assert_pause_quiet_R7 : assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_PAUSE) |-> (!cs_n && !sck));

  assert_ready_drop_R10 : assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_ready) |=> !tx_ready);

endmodule

// File: tb/sim_fcspi_master.sv
module sim_fcspi_master;

  localparam int CLK_PERIOD = 10;
  localparam int SCK_DIV    = 4;
  localparam int WD_LIMIT   = 100000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tx_valid = 1'b0;
  logic       tx_ready;
  logic [7:0] tx_data = 8'h00;
  logic       tx_hold = 1'b0;
  logic       rx_valid;
  logic [7:0] rx_data;
  logic       sck;
  logic       cs_n;
  logic       mosi;
  logic       miso = 1'b0;

  int checks = 0;
  int errors = 0;
  int clk_cnt = 0;

  fcspi_master #(.CLK_DIV(SCK_DIV), .W(8)) u0 (
    .clk(clk), .rst_n(rst_n), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .tx_data(tx_data), .tx_hold(tx_hold), .rx_valid(rx_valid), .rx_data(rx_data),
    .sck(sck), .cs_n(cs_n), .mosi(mosi), .miso(miso)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // behavioural slave and frame reference
  logic [7:0] txf[$];
  logic [7:0] srcv[$];
  logic       sck_p = 1'b0, mosi_p = 1'b0, cs_p = 1'b1, rxv_p = 1'b0;
  logic [7:0] sbyte = 8'h00;
  int rise_n = 0, fall_n = 0, nbits = 0, rxj = 0, t_rise = 0, t_fall = 0;
  bit last_chg = 0;

  always @(posedge clk) clk_cnt++;

  always @(negedge clk) begin
    if (rst_n) begin
      if (cs_n) begin
        if (sck) chk(0, "R1", "sck high with cs_n high", 1, 0);
        if (!cs_p) begin
          chk(rise_n == 8 * txf.size() + 1, "R8", "rising edges in frame",
              rise_n, 8 * txf.size() + 1);
          chk(!last_chg, "R8", "mosi changed on trailing edge", int'(last_chg), 0);
          chk(rxj == txf.size(), "R6", "received byte count", rxj, txf.size());
          chk(srcv.size() == txf.size(), "R9", "bytes seen by slave",
              srcv.size(), txf.size());
          rise_n = 0; fall_n = 0; nbits = 0; rxj = 0;
          txf.delete(); srcv.delete();
        end
      end else begin
        if (mosi !== mosi_p && !(sck && !sck_p))
          chk(0, "R4", "mosi moved away from rising edge", int'(mosi), int'(mosi_p));
        if (tx_ready && sck) chk(0, "R7", "sck high during pause", 1, 0);
        if (sck && !sck_p) begin
          rise_n++;
          last_chg = (mosi !== mosi_p);
          if (rise_n == 1) chk(cs_p == 1'b0, "R2", "cs_n setup before first edge", int'(cs_p), 0);
          else chk(clk_cnt - t_fall >= SCK_DIV/2, "R3", "low phase length",
                   clk_cnt - t_fall, SCK_DIV/2);
          t_rise = clk_cnt;
          if (rise_n >= 2) begin
            sbyte = {sbyte[6:0], mosi_p};
            nbits++;
            if (nbits == 8) begin
              nbits = 0;
              srcv.push_back(sbyte);
              if (srcv.size() <= txf.size())
                chk(sbyte == txf[srcv.size()-1], "R4", "byte taken by slave",
                    sbyte, txf[srcv.size()-1]);
              else chk(0, "R9", "slave got unexpected byte", sbyte, 0);
            end
          end
        end
        if (!sck && sck_p) begin
          logic [7:0] rb;
          int slot, b;
          fall_n++;
          chk(clk_cnt - t_rise == SCK_DIV/2, "R3", "high phase length",
              clk_cnt - t_rise, SCK_DIV/2);
          t_fall = clk_cnt;
          slot = (fall_n - 1) / 8;
          b = 7 - ((fall_n - 1) % 8);
          if (slot == 0) rb = 8'h3C;
          else if (slot - 1 < srcv.size()) rb = ~srcv[slot-1];
          else rb = 8'h00;
          miso = rb[b];
        end
      end
      if (rx_valid) begin
        logic [7:0] ex;
        if (rxv_p) chk(0, "R6", "rx_valid longer than one cycle", 1, 0);
        if (rxj < txf.size()) begin
          ex = (rxj == 0) ? 8'h3C : ~txf[rxj-1];
          chk(rx_data == ex, "R5", "received byte", rx_data, ex);
        end else chk(0, "R6", "extra received byte", rx_data, 0);
        rxj++;
      end
    end
    sck_p = sck; mosi_p = mosi; cs_p = cs_n; rxv_p = rx_valid;
  end

  task automatic send(input logic [7:0] d, input logic h);
    @(negedge clk);
    while (!tx_ready) @(negedge clk);
    tx_valid = 1'b1; tx_data = d; tx_hold = h;
    @(negedge clk);
    tx_valid = 1'b0;
    txf.push_back(d);
    chk(tx_ready == 1'b0, "R10", "tx_ready after accept", int'(tx_ready), 0);
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (!(cs_n && tx_ready)) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    if (clk_cnt > WD_LIMIT) begin
      chk(0, "WATCHDOG", "run did not finish", clk_cnt, WD_LIMIT);
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(cs_n == 1'b1, "R1", "reset cs_n", int'(cs_n), 1);
    chk(sck == 1'b0, "R1", "reset sck", int'(sck), 0);
    chk(tx_ready == 1'b1, "R1", "reset tx_ready", int'(tx_ready), 1);
    chk(rx_valid == 1'b0, "R1", "reset rx_valid", int'(rx_valid), 0);

    // single-byte frame
    send(8'hA5, 1'b0);
    wait_idle();

    // burst with pauses between bytes
    send(8'h01, 1'b1);
    repeat (10) @(negedge clk);
    send(8'h80, 1'b1);
    repeat (25) @(negedge clk);
    send(8'h5A, 1'b0);
    wait_idle();

    // back-to-back burst
    send(8'h00, 1'b1);
    send(8'hFF, 1'b1);
    send(8'hC3, 1'b1);
    send(8'h7E, 1'b0);
    wait_idle();

    // valid strobe while busy must be ignored (R9)
    send(8'h96, 1'b0);
    repeat (6) @(negedge clk);
    tx_valid = 1'b1; tx_data = 8'hFF; tx_hold = 1'b1;
    repeat (3) @(negedge clk);
    chk(tx_ready == 1'b0, "R9", "engine still busy", int'(tx_ready), 0);
    tx_valid = 1'b0;
    wait_idle();

    // two bytes with a long pause
    send(8'h3C, 1'b1);
    repeat (40) @(negedge clk);
    send(8'hE1, 1'b0);
    wait_idle();

    finish_run();
  end

endmodule